// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation converter. It sets the input track-and-hold to hold. It then puts a trial code on an external DAC and reads back a one-bit comparator decision. It settles one result bit per clock, working from the most significant bit down. When the last bit has been decided it registers the finished word and pulses an end-of-conversion flag.

A conversion takes one acquisition cycle with the hold released, followed by `RES_W` trial cycles with the hold engaged. Three ways of running are offered:

- **Single-shot:** one conversion for each start request.
- **Burst:** a counted run of back-to-back conversions.
- **Continuous:** free-running conversions that keep going while the mode input stays at continuous.

The comparator, the DAC and the track-and-hold sit outside the block.

Top module: `sar_seq_ctrl`

## Requirements
- R1: Out of reset, `dac_code_o`, `result_o`, `hold_o` and `eoc_o` are all zero.
- R2: The clock edge that samples `start_i` high in idle begins a conversion. There is one cycle with `hold_o` low, then `RES_W` cycles with `hold_o` high. `eoc_o` goes high after the (`RES_W`+1)-th edge following the start edge.
- R3: In the first trial cycle `dac_code_o` is midscale: only bit `RES_W`-1 is set. Each later trial keeps the bits already decided and also sets the next lower bit.
- R4: A comparator value of 1 (held input at or above the DAC level) keeps the trial bit, and 0 clears it. For `RES_W`=10 over 5000 mV, one step is about 4.88 mV and the result equals floor(mV*1024/5000).
- R5: A change of the analog input while `hold_o` is high has no effect on the result of that conversion.
- R6: `eoc_o` is a one-cycle pulse. `result_o` takes its new value in that same cycle and stays unchanged at all other times.
- R7: A start request that arrives while a conversion is running is ignored. No extra conversion follows.
- R8: Mode 2'b01 (burst) loads `burst_cnt_i` at start and runs that many conversions back to back, with one every `RES_W`+1 cycles. The block then goes idle. A count of 0 runs one conversion.
- R9: Mode 2'b10 (continuous) restarts after each conversion as long as `mode_i` is still 2'b10. If `mode_i` changes, the conversion in progress completes and the block then goes idle.
- R10: Modes 2'b00 and 2'b11 both run exactly one conversion per start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| mode_i | input | 2 | 00/11 single, 01 burst, 10 continuous |
| burst_cnt_i | input | BURST_W | Number of conversions in a burst |
| comp_i | input | 1 | Comparator: 1 when held input is at or above DAC level |
| dac_code_o | output | RES_W | Trial code to the DAC |
| hold_o | output | 1 | Track-and-hold control, 1 = hold |
| result_o | output | RES_W | Last finished conversion word |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The assertions take for granted that `comp_i` settles within the same cycle as `dac_code_o` and the held input. They also assume `mode_i` and `burst_cnt_i` are steady from the start request until the run ends, except for the deliberate exit from continuous mode. The bench meets these assumptions as follows:

- It derives `comp_i` combinationally from the current trial code and a model value, and that value is latched only while `hold_o` is low.
- It changes `mode_i` and `burst_cnt_i` only at a falling edge while the block is idle.
- It changes the input value only at falling edges, right after an end-of-conversion pulse or during hold.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_BURST  = 2'b01,
    MODE_CONT   = 2'b10,
    MODE_SPARE  = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SAMPLE = 2'b01,
    ST_TRIAL  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             eoc_o,
  output logic             last_trial_o
);
  localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] acc_q, mask_q, res_q;
  logic             eoc_q;

  // keep the trial bit when the held input is at or above the DAC level
  function automatic logic [RES_W-1:0] decide(input logic [RES_W-1:0] acc,
                                              input logic [RES_W-1:0] mask,
                                              input logic             cmp);
    return cmp ? (acc | mask) : acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mask_q <= '0;
      res_q  <= '0;
      eoc_q  <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      if (load_i) begin
        acc_q  <= '0;
        mask_q <= MSB_MASK;
      end else if (step_i) begin
        if (mask_q[0]) begin
          res_q  <= decide(acc_q, mask_q, comp_i);
          eoc_q  <= 1'b1;
          acc_q  <= '0;
          mask_q <= '0;
        end else begin
          acc_q  <= decide(acc_q, mask_q, comp_i);
          mask_q <= mask_q >> 1;
        end
      end
    end
  end

  assign dac_code_o   = acc_q | mask_q;
  assign result_o     = res_q;
  assign eoc_o        = eoc_q;
  assign last_trial_o = mask_q[0];

  assert_eoc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> !eoc_o);
  assert_result_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_o |-> $stable(result_o));
endmodule

// File: rtl/sar_mode_seq.sv
module sar_mode_seq
  import sar_pkg::*;
#(
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [BURST_W-1:0] burst_cnt_i,
  input  logic               last_trial_i,
  output logic               load_o,
  output logic               step_o,
  output logic               hold_o
);
  seq_state_e       state_q, state_d;
  conv_mode_e       mode_q, mode_d;
  logic [BURST_W-1:0] rem_q, rem_d;

  logic trial_active, conv_done, cont_live;

  function automatic logic [BURST_W-1:0] burst_load(input logic [BURST_W-1:0] cnt);
    return (cnt == '0) ? BURST_W'(1) : cnt;
  endfunction

  assign trial_active = (state_q == ST_TRIAL);
  assign conv_done    = trial_active && last_trial_i;
  assign cont_live    = (conv_mode_e'(mode_i) == MODE_CONT);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    rem_d   = rem_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SAMPLE;
        mode_d  = conv_mode_e'(mode_i);
        rem_d   = (conv_mode_e'(mode_i) == MODE_BURST) ? burst_load(burst_cnt_i) : '0;
      end
      ST_SAMPLE: state_d = ST_TRIAL;
      ST_TRIAL: if (last_trial_i) begin
        if (mode_q == MODE_CONT) begin
          state_d = cont_live ? ST_SAMPLE : ST_IDLE;
        end else if (mode_q == MODE_BURST) begin
          rem_d   = rem_q - 1'b1;
          state_d = (rem_q == BURST_W'(1)) ? ST_IDLE : ST_SAMPLE;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_SINGLE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      rem_q   <= rem_d;
    end
  end

  assign load_o = (state_q == ST_SAMPLE);
  assign step_o = trial_active;
  assign hold_o = trial_active;

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_active && !last_trial_i) |=> trial_active);
  assert_burst_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && mode_q == MODE_BURST) |-> (rem_q != '0));
  assert_single_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (mode_q == MODE_SINGLE || mode_q == MODE_SPARE)) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int RES_W   = 10,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [BURST_W-1:0] burst_cnt_i,
  input  logic               comp_i,
  output logic [RES_W-1:0]   dac_code_o,
  output logic               hold_o,
  output logic [RES_W-1:0]   result_o,
  output logic               eoc_o
);
  localparam logic [RES_W-1:0] MID_CODE = {1'b1, {(RES_W-1){1'b0}}};

  logic load_w, step_w, last_trial_w;

  sar_mode_seq #(.BURST_W(BURST_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .burst_cnt_i  (burst_cnt_i),
    .last_trial_i (last_trial_w),
    .load_o       (load_w),
    .step_o       (step_w),
    .hold_o       (hold_o)
  );

  sar_bit_engine #(.RES_W(RES_W)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_w),
    .step_i       (step_w),
    .comp_i       (comp_i),
    .dac_code_o   (dac_code_o),
    .result_o     (result_o),
    .eoc_o        (eoc_o),
    .last_trial_o (last_trial_w)
  );

  assert_first_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> (dac_code_o == MID_CODE));
  assert_eoc_after_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> $past(hold_o));
  assert_hold_has_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> (dac_code_o != '0));
endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  localparam int RES_W   = 10;
  localparam int BURST_W = 8;
  localparam int NVEC    = 8;
  localparam int VEC_MV  [NVEC] = '{0, 4, 5, 1234, 2500, 2502, 3333, 4999};
  localparam int VEC_EXP [NVEC] = '{0, 0, 1, 252, 512, 512, 682, 1023};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic [1:0]         mode_i = 2'b00;
  logic [BURST_W-1:0] burst_cnt_i = '0;
  logic               comp_i;
  logic [RES_W-1:0]   dac_code_o, result_o;
  logic               hold_o, eoc_o;

  int vin_mv = 0;
  int held_mv = 0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sar_seq_ctrl #(.RES_W(RES_W), .BURST_W(BURST_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .burst_cnt_i(burst_cnt_i), .comp_i(comp_i), .dac_code_o(dac_code_o),
    .hold_o(hold_o), .result_o(result_o), .eoc_o(eoc_o)
  );

  // track-and-hold model: follows the input only while hold is released
  always @(posedge clk) if (!hold_o) held_mv <= vin_mv;
  // ideal comparator on a 5000 mV span
  assign comp_i = (held_mv * 1024) >= (int'(dac_code_o) * 5000);

  function automatic int code_of(input int mv);
    int c;
    c = (mv * 1024) / 5000;
    return (c > 1023) ? 1023 : c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [1:0] m, input int cnt);
    @(negedge clk);
    mode_i = m;
    burst_cnt_i = BURST_W'(cnt);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // counts edges until eoc is seen at a falling edge
  task automatic wait_eoc(output int edges);
    edges = 0;
    while (edges < 64) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (eoc_o) return;
    end
    edges = -1;
  endtask

  task automatic quiet(input int n, output int eocs, output int holds);
    eocs = 0;
    holds = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (eoc_o) eocs++;
      if (hold_o) holds++;
    end
  endtask

  initial begin
    #750000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e, eocs, holds, first_code;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dac_code_o == 0 && result_o == 0 && !hold_o && !eoc_o, "R1 reset", int'(dac_code_o), 0);
    rst_n = 1'b1;

    // table: single-shot in modes 00 and 11 (R4, R2, R10)
    for (int v = 0; v < NVEC; v++) begin
      vin_mv = VEC_MV[v];
      kick((v % 2 == 0) ? 2'b00 : 2'b11, 0);
      wait_eoc(e);
      check(e == RES_W + 1, "R2 latency", e, RES_W + 1);
      check(int'(result_o) == VEC_EXP[v] && VEC_EXP[v] == code_of(VEC_MV[v]),
            "R4 code", int'(result_o), VEC_EXP[v]);
      @(negedge clk);
      check(!eoc_o, "R6 pulse width", int'(eoc_o), 0);
      quiet(15, eocs, holds);
      check(eocs == 0 && holds == 0, "R10 one conversion", eocs + holds, 0);
    end

    // R3 midscale first trial, R5 input change during hold ignored
    vin_mv = 3000;
    kick(2'b00, 0);
    check(!hold_o, "R2 acquire cycle", int'(hold_o), 0);
    @(negedge clk);
    first_code = int'(dac_code_o);
    check(hold_o && first_code == 512, "R3 midscale", first_code, 512);
    @(negedge clk);
    check(int'(dac_code_o) == 768, "R3 next trial", int'(dac_code_o), 768);
    vin_mv = 100;
    wait_eoc(e);
    check(int'(result_o) == code_of(3000), "R5 held input", int'(result_o), code_of(3000));

    // R7 start while busy ignored
    vin_mv = 1000;
    kick(2'b00, 0);
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_eoc(e);
    check(int'(result_o) == 204, "R7 result", int'(result_o), 204);
    quiet(25, eocs, holds);
    check(eocs == 0 && holds == 0, "R7 no restart", eocs + holds, 0);

    // R8 burst of 3 with spacing and changing input
    vin_mv = 500;
    kick(2'b01, 3);
    wait_eoc(e);
    check(int'(result_o) == 102, "R8 burst first", int'(result_o), 102);
    vin_mv = 1500;
    wait_eoc(e);
    check(e == RES_W + 1, "R8 spacing", e, RES_W + 1);
    check(int'(result_o) == 307, "R8 burst second", int'(result_o), 307);
    vin_mv = 4000;
    wait_eoc(e);
    check(int'(result_o) == 819, "R8 burst third", int'(result_o), 819);
    quiet(30, eocs, holds);
    check(eocs == 0 && holds == 0, "R8 burst ends", eocs + holds, 0);

    // R8 count of zero runs once
    vin_mv = 2500;
    kick(2'b01, 0);
    wait_eoc(e);
    check(e == RES_W + 1 && int'(result_o) == 512, "R8 zero count", int'(result_o), 512);
    quiet(30, eocs, holds);
    check(eocs == 0, "R8 zero count once", eocs, 0);

    // R9 continuous, then stop
    vin_mv = 2000;
    kick(2'b10, 0);
    for (int k = 0; k < 3; k++) begin
      wait_eoc(e);
      check(e > 0 && int'(result_o) == 409, "R9 continuous", int'(result_o), 409);
    end
    mode_i = 2'b00;
    quiet(40, eocs, holds);
    check(eocs == 1, "R9 stop after current", eocs, 1);
    quiet(20, eocs, holds);
    check(eocs == 0 && holds == 0, "R9 idle", eocs + holds, 0);
    check(dac_code_o == 0, "R1 idle code", int'(dac_code_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule